// File: doc/BRIEF.md
# Translation Table Update Command Engine

This block owns a small table of 64-bit translation entries and carries out commands that change or inspect it. A command names a table identifier, a bus address, an argument and a page count. The operation is one of four: store one entry, fetch one entry, fill a run of pages with one value, or load a run of entries from a list held in system memory. Every command ends with one response cycle that carries a success or parameter-error status.

The engine works one page per step. It first validates the identifier and the per-operation limits. It then turns the page-aligned bus address into a table index and walks forward one page at a time. It stops at the first index that falls outside the table and keeps whatever it has already written. List loads pull big-endian 64-bit words through a single-outstanding memory read port. Every entry write is reported on a notification port, so that cached translations elsewhere can be dropped.

Top module: `tce_cmd_engine`

## Requirements
- R1: A command whose identifier has any of bits 63..32 set, or whose low 32 bits differ from the TABLE_ID parameter, ends with status 1 (parameter error), writes nothing and emits no notification.
- R2: The bus address is aligned down by clearing its low PAGE_SHIFT bits. The index is (aligned address - BUS_OFFSET) >> PAGE_SHIFT, taken as unsigned 64-bit. An index at or beyond DEPTH gives status 1.
- R3: Operation code 0 stores cmd_arg at the index. Code 1 returns the stored entry on rsp_data with status 0. rsp_data is zero whenever the status is 1, and zero for every operation other than a read.
- R4: Operation code 2 (fill) with a count of zero, or a count above DEPTH, gives status 1 with no write. Otherwise it writes cmd_arg to count consecutive pages starting at the index.
- R5: Operation code 3 (list load) with a count of zero, a count above 512, or a list address (cmd_arg) whose low 12 bits are not all zero gives status 1 before any memory request is issued.
- R6: A list load reads entry i from address cmd_arg + 8*i. It byte-swaps the big-endian word into host order and writes it to the page i pages past the start. Only one request is outstanding at a time, and the request is held stable until it is accepted.
- R7: A fill or list load stops at the first page outside the table with status 1. Pages written before that point keep their new values. A list load checks the page before fetching, so no memory read is made for the failing page.
- R8: Each entry write produces exactly one ntf_valid pulse, one cycle after the write. The pulse carries iova = the aligned page address, xlat = the entry with its low PAGE_SHIFT bits cleared, mask = 2^PAGE_SHIFT - 1, and perm = the entry's bits 1..0 (bit 0 read allowed, bit 1 write allowed).
- R9: Reset clears every table entry to zero.
- R10: cmd_ready is high only while the engine is idle. busy is high from acceptance through the single response cycle. rsp_valid lasts exactly one cycle. Status 0 means success and status 1 means parameter error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and taking a command |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list load |
| cmd_id | input | 64 | Table identifier |
| cmd_addr | input | 64 | Bus address of the first page |
| cmd_arg | input | 64 | Entry value (write, fill) or list address (load) |
| cmd_count | input | 32 | Page count for fill and load |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 1 | 0 success, 1 parameter error |
| rsp_data | output | 64 | Entry returned by a successful read |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 8-byte slot |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Big-endian read data |
| ntf_valid | output | 1 | Mapping change notification |
| ntf_iova | output | 64 | Page-aligned I/O address |
| ntf_xlat | output | 64 | Translated address, in-page bits cleared |
| ntf_mask | output | 64 | In-page offset mask |
| ntf_perm | output | 2 | Decoded permission |

## Verification
Two things land in the same cycle: the notification for the last entry a command writes, and that command's response strobe. The notification is registered one cycle behind its write, and the final write moves the engine straight into its response state. Single writes, full fills and full list loads provoke this overlap. The bench samples ntf_valid in the response cycle and also checks that the total notification count, including that last pulse, equals the number of pages written. Runs that fail partway show the other ordering: the last notification comes before the failing check, and the bench confirms that the count still matches the pages written.

// File: rtl/tce_cmd_pkg.sv
// Shared types for the translation table command engine.
// Assumes entries and addresses share one 64-bit width.
package tce_cmd_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_FILL  = 2'd2,
        OP_LOAD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RDWR = 2'd3
    } perm_e;

    localparam logic STAT_OK    = 1'b0;
    localparam logic STAT_PARAM = 1'b1;

    // Map the two access bits of an entry onto the permission type.
    function automatic perm_e decode_perm(input logic [1:0] bits);
        case (bits)
            2'd0:    return PERM_NONE;
            2'd1:    return PERM_RD;
            2'd2:    return PERM_WR;
            default: return PERM_RDWR;
        endcase
    endfunction

endpackage

// File: rtl/tce_index_calc.sv
// Turns a page-aligned bus address into a table index and a range flag.
// Assumes the address was already aligned; the subtraction wraps unsigned,
// so addresses below the window land far out of range.
module tce_index_calc #(
    parameter int          W          = 64,
    parameter logic [63:0] BUS_OFFSET = 64'h0,
    parameter int          PAGE_SHIFT = 12,
    parameter int          DEPTH      = 16,
    localparam int         IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [W-1:0]     addr,
    output logic [IDX_W-1:0] idx,
    output logic             in_range
);
    localparam logic [W-1:0] DEPTH_W = W'(DEPTH);

    logic [W-1:0] offs;
    logic [W-1:0] page;

    // Offset from the window base, then page number and bound test.
    always_comb begin
        offs     = addr - W'(BUS_OFFSET);
        page     = offs >> PAGE_SHIFT;
        in_range = (page < DEPTH_W);
        idx      = page[IDX_W-1:0];
    end
endmodule

// File: rtl/tce_entry_store.sv
// Register table of translation entries with one write port, one
// combinational read port and a registered change notification.
// Assumes the caller only writes in-range indices.
module tce_entry_store
    import tce_cmd_pkg::*;
#(
    parameter int  W          = 64,
    parameter int  PAGE_SHIFT = 12,
    parameter int  DEPTH      = 16,
    localparam int IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     wiova,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata,
    output logic             ntf_valid,
    output logic [W-1:0]     ntf_iova,
    output logic [W-1:0]     ntf_xlat,
    output logic [W-1:0]     ntf_mask,
    output logic [1:0]       ntf_perm
);
    localparam logic [W-1:0] PG_MASK = (W'(1) << PAGE_SHIFT) - W'(1);

    logic [W-1:0] tbl [DEPTH];

    // Entry storage: cleared by reset, one entry updated per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= '0;
            end
        end else if (we) begin
            tbl[widx] <= wdata;
        end
    end

    // Read port.
    always_comb rdata = tbl[ridx];

    // Notification register: reports each write one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_valid <= 1'b0;
            ntf_iova  <= '0;
            ntf_xlat  <= '0;
            ntf_perm  <= PERM_NONE;
        end else begin
            ntf_valid <= we;
            if (we) begin
                ntf_iova <= wiova & ~PG_MASK;
                ntf_xlat <= wdata & ~PG_MASK;
                ntf_perm <= decode_perm(wdata[1:0]);
            end
        end
    end

    assign ntf_mask = PG_MASK;
endmodule

// File: rtl/tce_list_fetch.sv
// Single-outstanding memory reader for list words. A start pulse latches
// the slot address, the request is held until accepted, and the returned
// big-endian word is byte-swapped into host order.
// Assumes W is a multiple of 8 and responses arrive in order.
module tce_list_fetch #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_addr,
    output logic         req_valid,
    input  logic         req_ready,
    output logic [W-1:0] req_addr,
    input  logic         rsp_valid,
    input  logic [W-1:0] rsp_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int NBYTES = W / 8;

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fstate_e;
    fstate_e fstate;

    // Request sequencer: idle, request held, waiting for data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstate   <= F_IDLE;
            req_addr <= '0;
        end else begin
            case (fstate)
                F_IDLE: if (start) begin
                    req_addr <= start_addr;
                    fstate   <= F_REQ;
                end
                F_REQ:  if (req_ready) fstate <= F_WAIT;
                F_WAIT: if (rsp_valid) fstate <= F_IDLE;
                default: fstate <= F_IDLE;
            endcase
        end
    end

    assign req_valid = (fstate == F_REQ);
    assign out_valid = (fstate == F_WAIT) && rsp_valid;

    // Byte reversal: the lowest memory byte is the most significant.
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign out_data[8*b +: 8] = rsp_data[W-8-8*b +: 8];
    end
endmodule

// File: rtl/tce_cmd_engine.sv
// Command engine for a translation entry table: validates a command,
// walks its pages one per step, writes or reads entries, fetches list
// words for list loads and returns one status cycle.
// Assumes one command at a time; in-page bits of the bus address are dropped.
module tce_cmd_engine
    import tce_cmd_pkg::*;
#(
    parameter logic [31:0] TABLE_ID         = 32'h8000_0001,
    parameter logic [63:0] BUS_OFFSET       = 64'h0000_0000_0001_0000,
    parameter int          PAGE_SHIFT       = 12,
    parameter int          DEPTH            = 16,
    parameter int          MAX_LIST         = 512,
    parameter int          LIST_ALIGN_SHIFT = 12,
    parameter int          W                = 64,
    parameter int          CNT_W            = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [W-1:0]     cmd_id,
    input  logic [W-1:0]     cmd_addr,
    input  logic [W-1:0]     cmd_arg,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_status,
    output logic [W-1:0]     rsp_data,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [W-1:0]     mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [W-1:0]     mem_rsp_data,
    output logic             ntf_valid,
    output logic [W-1:0]     ntf_iova,
    output logic [W-1:0]     ntf_xlat,
    output logic [W-1:0]     ntf_mask,
    output logic [1:0]       ntf_perm
);
    localparam int               IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [W-1:0]     PG_SIZE = W'(1) << PAGE_SHIFT;
    localparam logic [W-1:0]     PG_MASK = PG_SIZE - W'(1);
    localparam logic [W-1:0]     SLOT    = W'(8);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_LIST);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef enum logic [2:0] {S_IDLE, S_CHECK, S_STEP, S_FETCH, S_DONE} state_e;

    state_e         state;
    op_e            op_q;
    logic [W-1:0]   id_q;
    logic [W-1:0]   addr_q;
    logic [W-1:0]   arg_q;
    logic [CNT_W-1:0] cnt_q;
    logic           st_q;
    logic [W-1:0]   data_q;

    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [W-1:0]     rd_entry;
    logic             we;
    logic [W-1:0]     wdata;
    logic             f_start;
    logic             f_valid;
    logic [W-1:0]     f_data;
    logic             pre_bad;
    logic             last_pg;

    tce_index_calc #(
        .W(W), .BUS_OFFSET(BUS_OFFSET), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(DEPTH)
    ) u_idx (
        .addr(addr_q), .idx(idx), .in_range(in_range)
    );

    tce_entry_store #(
        .W(W), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(idx), .wdata(wdata),
        .wiova(addr_q), .ridx(idx), .rdata(rd_entry),
        .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
        .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
    );

    tce_list_fetch #(.W(W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(f_start), .start_addr(arg_q),
        .req_valid(mem_req_valid), .req_ready(mem_req_ready),
        .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid),
        .rsp_data(mem_rsp_data), .out_valid(f_valid), .out_data(f_data)
    );

    // Up-front checks on identifier and per-operation limits.
    always_comb begin
        pre_bad = (id_q[W-1:32] != '0) || (id_q[31:0] != TABLE_ID);
        if (op_q == OP_FILL) begin
            pre_bad = pre_bad || (cnt_q == '0) || (cnt_q > DEPTH_C);
        end
        if (op_q == OP_LOAD) begin
            pre_bad = pre_bad || (cnt_q == '0) || (cnt_q > MAX_C)
                    || (arg_q[LIST_ALIGN_SHIFT-1:0] != '0);
        end
    end

    // Write strobe, write data source and fetch kick-off.
    always_comb begin
        last_pg = (cnt_q == ONE_C);
        we      = ((state == S_STEP) && in_range
                  && ((op_q == OP_WRITE) || (op_q == OP_FILL)))
               || ((state == S_FETCH) && f_valid);
        wdata   = (state == S_FETCH) ? f_data : arg_q;
        f_start = (state == S_STEP) && in_range && (op_q == OP_LOAD);
    end

    // Command sequencer: accept, check, walk pages, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_WRITE;
            id_q   <= '0;
            addr_q <= '0;
            arg_q  <= '0;
            cnt_q  <= '0;
            st_q   <= STAT_OK;
            data_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= op_e'(cmd_op);
                    id_q   <= cmd_id;
                    addr_q <= cmd_addr & ~PG_MASK;
                    arg_q  <= cmd_arg;
                    cnt_q  <= cmd_op[1] ? cmd_count : ONE_C;
                    st_q   <= STAT_OK;
                    data_q <= '0;
                    state  <= S_CHECK;
                end
                S_CHECK: begin
                    if (pre_bad) begin
                        st_q  <= STAT_PARAM;
                        state <= S_DONE;
                    end else begin
                        state <= S_STEP;
                    end
                end
                S_STEP: begin
                    if (!in_range) begin
                        st_q  <= STAT_PARAM;
                        state <= S_DONE;
                    end else if (op_q == OP_READ) begin
                        data_q <= rd_entry;
                        state  <= S_DONE;
                    end else if (op_q == OP_LOAD) begin
                        state <= S_FETCH;
                    end else if (last_pg) begin
                        state <= S_DONE;
                    end else begin
                        cnt_q  <= cnt_q - ONE_C;
                        addr_q <= addr_q + PG_SIZE;
                    end
                end
                S_FETCH: if (f_valid) begin
                    arg_q <= arg_q + SLOT;
                    if (last_pg) begin
                        state <= S_DONE;
                    end else begin
                        cnt_q  <= cnt_q - ONE_C;
                        addr_q <= addr_q + PG_SIZE;
                        state  <= S_STEP;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_ready  = (state == S_IDLE);
    assign busy       = (state != S_IDLE);
    assign rsp_valid  = (state == S_DONE);
    assign rsp_status = st_q;
    assign rsp_data   = data_q;
endmodule

// File: rtl/tce_cmd_engine_chk.sv
// Port-level protocol checks for the command engine, bound to every instance.
module tce_cmd_engine_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_ready,
    input logic         busy,
    input logic         rsp_valid,
    input logic         rsp_status,
    input logic [W-1:0] rsp_data,
    input logic         mem_req_valid,
    input logic         mem_req_ready,
    input logic [W-1:0] mem_req_addr,
    input logic         ntf_valid,
    input logic [W-1:0] ntf_iova,
    input logic [W-1:0] ntf_xlat,
    input logic [W-1:0] ntf_mask
);
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (busy && !cmd_ready));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !ntf_valid));

    assert_err_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status) |-> (rsp_data == '0));

    assert_ntf_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (((ntf_iova & ntf_mask) == '0) && ((ntf_xlat & ntf_mask) == '0)));

    assert_ntf_in_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> busy);

    assert_req_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind tce_cmd_engine tce_cmd_engine_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .ntf_valid(ntf_valid), .ntf_iova(ntf_iova),
    .ntf_xlat(ntf_xlat), .ntf_mask(ntf_mask)
);

// File: tb/tce_cmd_engine_tb.sv
module tce_cmd_engine_tb;
    localparam logic [63:0] ID_OK     = 64'h0000_0000_8000_0001;
    localparam logic [63:0] LIST_BASE = 64'h2000;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] id;
        logic [63:0] addr;
        logic [63:0] arg;
        logic [31:0] cnt;
        logic        st;
        logic [63:0] data;
        logic [31:0] nntf;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R3 R2: single write, in-page bits dropped
        '{2'd0, ID_OK, 64'h10123, 64'hAAAA_B003, 32'd0, 1'b0, 64'h0, 32'd1},
        '{2'd1, ID_OK, 64'h10FFF, 64'h0, 32'd0, 1'b0, 64'hAAAA_B003, 32'd0},
        // R1: upper identifier bits, mismatched identifier
        '{2'd0, 64'h1_8000_0001, 64'h10000, 64'h1, 32'd0, 1'b1, 64'h0, 32'd0},
        '{2'd0, 64'h8000_0002, 64'h10000, 64'h1, 32'd0, 1'b1, 64'h0, 32'd0},
        // R2: index at DEPTH, below the window
        '{2'd1, ID_OK, 64'h20000, 64'h0, 32'd0, 1'b1, 64'h0, 32'd0},
        '{2'd1, ID_OK, 64'h0F000, 64'h0, 32'd0, 1'b1, 64'h0, 32'd0},
        // R2 R3: last valid index
        '{2'd0, ID_OK, 64'h1F000, 64'h5555_5001, 32'd0, 1'b0, 64'h0, 32'd1},
        '{2'd1, ID_OK, 64'h1F000, 64'h0, 32'd0, 1'b0, 64'h5555_5001, 32'd0},
        // R4: fill three pages, check last and one past
        '{2'd2, ID_OK, 64'h13000, 64'h7000_0002, 32'd3, 1'b0, 64'h0, 32'd3},
        '{2'd1, ID_OK, 64'h15000, 64'h0, 32'd0, 1'b0, 64'h7000_0002, 32'd0},
        '{2'd1, ID_OK, 64'h16000, 64'h0, 32'd0, 1'b0, 64'h0, 32'd0},
        // R4: count above DEPTH, count zero
        '{2'd2, ID_OK, 64'h10000, 64'h1, 32'd17, 1'b1, 64'h0, 32'd0},
        '{2'd2, ID_OK, 64'h10000, 64'h1, 32'd0, 1'b1, 64'h0, 32'd0},
        // R7: fill runs off the end after two pages
        '{2'd2, ID_OK, 64'h1E000, 64'h9000_0003, 32'd4, 1'b1, 64'h0, 32'd2},
        '{2'd1, ID_OK, 64'h1F000, 64'h0, 32'd0, 1'b0, 64'h9000_0003, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_id = '0;
    logic [63:0] cmd_addr = '0;
    logic [63:0] cmd_arg = '0;
    logic [31:0] cmd_count = '0;
    logic        busy;
    logic        rsp_valid;
    logic        rsp_status;
    logic [63:0] rsp_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        ntf_valid;
    logic [63:0] ntf_iova;
    logic [63:0] ntf_xlat;
    logic [63:0] ntf_mask;
    logic [1:0]  ntf_perm;

    int checks = 0;
    int errors = 0;
    int ntf_total = 0;
    int req_total = 0;
    logic [63:0] last_iova, last_xlat, last_mask;
    logic [1:0]  last_perm;
    logic [63:0] lm [8];

    always #10 clk = ~clk;

    tce_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_addr(cmd_addr), .cmd_arg(cmd_arg),
        .cmd_count(cmd_count), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .ntf_valid(ntf_valid), .ntf_iova(ntf_iova),
        .ntf_xlat(ntf_xlat), .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
    );

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56-8*b +: 8];
        return r;
    endfunction

    // Memory model: ready toggles, one-cycle read latency, big-endian storage.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_req_ready <= ~mem_req_ready;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= bswap(lm[3'((mem_req_addr - LIST_BASE) >> 3)]);
                req_total     <= req_total + 1;
            end
        end
    end

    // Notification monitor.
    always @(negedge clk) begin
        if (ntf_valid) begin
            ntf_total <= ntf_total + 1;
            last_iova <= ntf_iova;
            last_xlat <= ntf_xlat;
            last_mask <= ntf_mask;
            last_perm <= ntf_perm;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [63:0] id,
                           input logic [63:0] addr, input logic [63:0] arg,
                           input logic [31:0] cnt, output logic st,
                           output logic [63:0] data, output int nntf,
                           output int nreq, output logic ntf_at_rsp);
        int n0, r0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        n0 = ntf_total;
        r0 = req_total;
        cmd_op = op; cmd_id = id; cmd_addr = addr; cmd_arg = arg; cmd_count = cnt;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && !cmd_ready, "R10 busy after accept", {62'd0, busy, cmd_ready}, 64'h2);
        while (!rsp_valid) @(negedge clk);
        st = rsp_status;
        data = rsp_data;
        ntf_at_rsp = ntf_valid;
        @(posedge clk);
        #1;
        nntf = ntf_total - n0;
        nreq = req_total - r0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        logic st, at;
        logic [63:0] d;
        int nn, nr;
        lm[0] = 64'h1111_2222_3333_4001;
        lm[1] = 64'h0123_4567_89AB_C002;
        lm[2] = 64'hFEDC_BA98_7654_3213;
        for (int i = 3; i < 8; i++) lm[i] = 64'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready && !busy && !rsp_valid && !ntf_valid && !mem_req_valid,
            "R10 reset state", {59'd0, cmd_ready, busy, rsp_valid, ntf_valid, mem_req_valid},
            64'h10);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_cmd(VECS[v].op, VECS[v].id, VECS[v].addr, VECS[v].arg, VECS[v].cnt,
                    st, d, nn, nr, at);
            chk(st == VECS[v].st, $sformatf("R1 R2 R4 R7 vec %0d status", v),
                64'(st), 64'(VECS[v].st));
            chk(d == VECS[v].data, $sformatf("R3 vec %0d data", v), d, VECS[v].data);
            chk(nn == int'(VECS[v].nntf), $sformatf("R8 vec %0d notifications", v),
                64'(nn), 64'(VECS[v].nntf));
        end

        // R8: notification fields for one write, coinciding with the response
        run_cmd(2'd0, ID_OK, 64'h11ABC, 64'hDEAD_BEEF_F123_4567, 32'd0, st, d, nn, nr, at);
        chk(at == 1'b1, "R8 notify in response cycle", 64'(at), 64'h1);
        chk(last_iova == 64'h11000, "R8 iova", last_iova, 64'h11000);
        chk(last_xlat == 64'hDEAD_BEEF_F123_4000, "R8 xlat", last_xlat, 64'hDEAD_BEEF_F123_4000);
        chk(last_mask == 64'hFFF, "R8 mask", last_mask, 64'hFFF);
        chk(last_perm == 2'd3, "R8 perm", 64'(last_perm), 64'h3);

        // R6: list load of three entries
        run_cmd(2'd3, ID_OK, 64'h18000, LIST_BASE, 32'd3, st, d, nn, nr, at);
        chk(st == 1'b0, "R6 load status", 64'(st), 64'h0);
        chk(nr == 3, "R6 load requests", 64'(nr), 64'h3);
        chk(nn == 3 && at, "R6 load notifications", 64'(nn), 64'h3);
        chk(last_iova == 64'h1A000, "R6 last iova", last_iova, 64'h1A000);
        chk(last_xlat == 64'hFEDC_BA98_7654_3000, "R6 last xlat", last_xlat, 64'hFEDC_BA98_7654_3000);
        chk(last_perm == 2'd3, "R6 last perm", 64'(last_perm), 64'h3);
        run_cmd(2'd1, ID_OK, 64'h19000, 64'h0, 32'd0, st, d, nn, nr, at);
        chk(d == lm[1], "R6 swapped entry", d, lm[1]);

        // R5: misaligned list, oversize list
        run_cmd(2'd3, ID_OK, 64'h10000, 64'h2008, 32'd2, st, d, nn, nr, at);
        chk(st == 1'b1 && nr == 0 && nn == 0, "R5 misaligned list", 64'(nr), 64'h0);
        run_cmd(2'd3, ID_OK, 64'h10000, LIST_BASE, 32'd513, st, d, nn, nr, at);
        chk(st == 1'b1 && nr == 0 && nn == 0, "R5 oversize list", 64'(st), 64'h1);

        // R7: list load runs off the end; no fetch for the failing page
        run_cmd(2'd3, ID_OK, 64'h1E000, LIST_BASE, 32'd3, st, d, nn, nr, at);
        chk(st == 1'b1, "R7 load status", 64'(st), 64'h1);
        chk(nr == 2 && nn == 2, "R7 load partial", 64'(nr), 64'h2);
        run_cmd(2'd1, ID_OK, 64'h1E000, 64'h0, 32'd0, st, d, nn, nr, at);
        chk(d == lm[0], "R7 earlier entry kept", d, lm[0]);

        // R9: reset clears entries
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_cmd(2'd1, ID_OK, 64'h1F000, 64'h0, 32'd0, st, d, nn, nr, at);
        chk(st == 1'b0 && d == 64'h0, "R9 entry cleared", d, 64'h0);
        run_cmd(2'd1, ID_OK, 64'h19000, 64'h0, 32'd0, st, d, nn, nr, at);
        chk(d == 64'h0, "R9 loaded entry cleared", d, 64'h0);

        finish_run();
    end
endmodule